// File: doc/BRIEF.md
# Mode-Selectable I/O Port with External-Bus Takeover

This block controls an 8-bit general-purpose I/O port of a microcontroller. Software picks one drive style for the whole port, push-pull or open-drain, and writes an output data register. For each pin the block produces a pull-up enable, a pull-down enable and an output enable, which go to the analog pad. A pin whose data bit is 1 in open-drain mode is left floating, so the pin can be read as an input or pulled high by an external resistor.

When the external-memory sequencer claims the port, the pins carry its multiplexed address/data bits instead of the software data. While the sequencer drives, the pins are push-pull. While it reads, they float. When it releases the port, the stored software data and mode return to the pins, including any values written while the bus held the port. Each pin level passes through a two-flop synchroniser into a readable pin register. Software can then tell pins held low by this port apart from pins pulled high from outside.

Top module: `ovr_port`

## Requirements
- R1: After reset the data register reads all ones, the mode reads 0 (open-drain), every pull-up, pull-down and output enable is 0, and the pin register reads 0.
- R2: A cycle with `mode_wr` high loads `mode_din` into the mode register, visible on `mode_q` and on the drive outputs from the next cycle. Mode 1 is push-pull and mode 0 is open-drain, and the mode applies to all pins at once.
- R3: With the bus not in control and mode 1, bit i of `pu_en` equals data bit i and bit i of `pd_en` equals its inverse.
- R4: With the bus not in control and mode 0, `pu_en` is 0 and bit i of `pd_en` is the inverse of data bit i. A data bit of 1 therefore leaves that pin with `oe` 0 (high-impedance).
- R5: For every pin, `oe` is the OR of its pull-up and pull-down enables, and the two enables are never 1 together.
- R6: While `bus_own` and `bus_drv` are both 1, `pu_en` equals `bus_ad` and `pd_en` equals its inverse, in either mode.
- R7: While `bus_own` is 1 and `bus_drv` is 0, every pull-up, pull-down and output enable is 0, in either mode.
- R8: Data and mode writes made while `bus_own` is 1 are stored without changing the pins. In the cycle `bus_own` returns to 0, the pins show the stored software data and mode.
- R9: `pin_q` equals the value `pin_in` had two rising clock edges earlier.
- R10: A cycle with `data_wr` high loads `data_din` into the data register, readable on `data_q` and driving the pins from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_din | input | 8 | New data register value |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_din | input | 1 | New mode: 1 push-pull, 0 open-drain |
| bus_own | input | 1 | External bus has control of the port |
| bus_drv | input | 1 | Bus is driving (1) or reading (0) |
| bus_ad | input | 8 | Address/data bits from the bus sequencer |
| pin_in | input | 8 | Pad input levels |
| pu_en | output | 8 | Per-pin pull-up driver enable |
| pd_en | output | 8 | Per-pin pull-down driver enable |
| oe | output | 8 | Per-pin output enable |
| data_q | output | 8 | Data register readback |
| mode_q | output | 1 | Mode register readback |
| pin_q | output | 8 | Synchronised pin levels |

## Verification
All 256 data values are applied in each drive mode. This separates the push-pull mapping from the open-drain mapping bit by bit and exposes any per-pin swap or inversion. All 256 address/data values are applied with the bus driving in both software modes, and again with the bus reading, to show that the bus overrides the mode completely. The bench writes new data and mode while the bus holds the port and checks that they appear only after release. All 256 pin patterns are swept through the input path at the two-edge latency, to show both the delay and the bit order.

// File: rtl/ovr_port_pkg.sv
package ovr_port_pkg;

  localparam logic MODE_OPEN = 1'b0;
  localparam logic MODE_PUSH = 1'b1;

  // Per-pin driver decision, returned as {pull_up, pull_down}.
  function automatic logic [1:0] pin_drive(
    input logic sw_bit,
    input logic push,
    input logic bus_own,
    input logic bus_drv,
    input logic bus_bit
  );
    logic up, dn;
    if (bus_own) begin
      up = bus_drv & bus_bit;
      dn = bus_drv & ~bus_bit;
    end else begin
      up = push & sw_bit;
      dn = ~sw_bit;
    end
    return {up, dn};
  endfunction

endpackage

// File: rtl/ovr_port_regs.sv
module ovr_port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic [W-1:0] data_din,
  input  logic         mode_wr,
  input  logic         mode_din,
  output logic [W-1:0] data_q,
  output logic         mode_q
);
  import ovr_port_pkg::*;

  localparam logic [W-1:0] DATA_RST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      mode_q <= MODE_OPEN;
    end else begin
      if (data_wr) data_q <= data_din;
      if (mode_wr) mode_q <= mode_din;
    end
  end

  assert_data_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> data_q == $past(data_din));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode_q == $past(mode_din));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

endmodule

// File: rtl/ovr_port_drive.sv
module ovr_port_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_data,
  input  logic         sw_mode,
  input  logic         bus_own,
  input  logic         bus_drv,
  input  logic [W-1:0] bus_ad,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] oe
);
  import ovr_port_pkg::*;

  wire push_sel = (sw_mode == MODE_PUSH);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] drv;
    always_comb drv = pin_drive(sw_data[i], push_sel, bus_own, bus_drv, bus_ad[i]);
    assign pu_en[i] = drv[1];
    assign pd_en[i] = drv[0];
    assign oe[i]    = drv[1] | drv[0];
  end

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0);

  assert_open_drain_no_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_own && !push_sel) |-> pu_en == '0);

endmodule

// File: rtl/ovr_port_sync.sv
module ovr_port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] sync_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_first <= '0;
      pin_q      <= '0;
    end else begin
      sync_first <= pin_in;
      pin_q      <= sync_first;
    end
  end

  assert_sync_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pin_q == $past(sync_first));

endmodule

// File: rtl/ovr_port.sv
module ovr_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic [W-1:0] data_din,
  input  logic         mode_wr,
  input  logic         mode_din,
  input  logic         bus_own,
  input  logic         bus_drv,
  input  logic [W-1:0] bus_ad,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] oe,
  output logic [W-1:0] data_q,
  output logic         mode_q,
  output logic [W-1:0] pin_q
);

  // Named internal events for the checks below.
  wire bus_read_phase  = bus_own & ~bus_drv;
  wire bus_drive_phase = bus_own & bus_drv;

  ovr_port_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .data_din(data_din),
    .mode_wr(mode_wr), .mode_din(mode_din),
    .data_q(data_q), .mode_q(mode_q)
  );

  ovr_port_drive #(.W(W)) drive_i (
    .clk(clk), .rst_n(rst_n),
    .sw_data(data_q), .sw_mode(mode_q),
    .bus_own(bus_own), .bus_drv(bus_drv), .bus_ad(bus_ad),
    .pu_en(pu_en), .pd_en(pd_en), .oe(oe)
  );

  ovr_port_sync #(.W(W)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .pin_in(pin_in), .pin_q(pin_q)
  );

  assert_bus_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read_phase |-> oe == '0);

  assert_bus_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_phase |-> (pu_en == bus_ad && pd_en == ~bus_ad));

  assert_release_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own) |-> pd_en == ~data_q);

  assert_oe_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe == (pu_en | pd_en));

endmodule

// File: tb/ovr_port_tb_top.sv
`timescale 1ns/1ps
module ovr_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_wr = 0, mode_wr = 0, mode_din = 0, bus_own = 0, bus_drv = 0;
  logic [W-1:0] data_din = '0, bus_ad = '0, pin_in = '0;
  logic [W-1:0] pu_en, pd_en, oe, data_q, pin_q;
  logic mode_q;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ovr_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .data_din(data_din),
    .mode_wr(mode_wr), .mode_din(mode_din),
    .bus_own(bus_own), .bus_drv(bus_drv), .bus_ad(bus_ad),
    .pin_in(pin_in),
    .pu_en(pu_en), .pd_en(pd_en), .oe(oe),
    .data_q(data_q), .mode_q(mode_q), .pin_q(pin_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected driver levels, restated arithmetically.
  function automatic int exp_up(int mode, int own, int drv, int ad, int d);
    if (own != 0) return (drv != 0) ? ad : 0;
    return mode * d;
  endfunction
  function automatic int exp_dn(int own, int drv, int ad, int d);
    if (own != 0) return (drv != 0) ? 255 - ad : 0;
    return 255 - d;
  endfunction

  task automatic check_drive(input string tag, input int mode, input int d);
    int u, n;
    u = exp_up(mode, int'(bus_own), int'(bus_drv), int'(bus_ad), d);
    n = exp_dn(int'(bus_own), int'(bus_drv), int'(bus_ad), d);
    check({tag, " pu"}, int'(pu_en), u);
    check({tag, " pd"}, int'(pd_en), n);
    check({tag, " oe R5"}, int'(oe), u + n);
  endtask

  task automatic wr_data(input int v);
    @(negedge clk);
    data_wr = 1; data_din = W'(v);
    @(negedge clk);
    data_wr = 0;
  endtask

  task automatic wr_mode(input int v);
    @(negedge clk);
    mode_wr = 1; mode_din = v[0];
    @(negedge clk);
    mode_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", int'(data_q), 255);
    check("R1 mode", int'(mode_q), 0);
    check("R1 oe", int'(oe), 0);
    check("R1 pu", int'(pu_en), 0);
    check("R1 pd", int'(pd_en), 0);
    check("R1 pin", int'(pin_q), 0);
    rst_n = 1;
    @(negedge clk);

    // R4 / R10: open-drain sweep
    for (int d = 0; d < 256; d++) begin
      wr_data(d);
      check("R10 data_q", int'(data_q), d);
      check_drive("R4 open", 0, d);
    end
    // R2 / R3: push-pull sweep
    wr_mode(1);
    check("R2 mode_q", int'(mode_q), 1);
    for (int d = 0; d < 256; d++) begin
      wr_data(d);
      check_drive("R3 push", 1, d);
    end

    // R6 / R7: bus sweeps in both modes
    for (int m = 0; m < 2; m++) begin
      wr_mode(m);
      wr_data(8'hA5);
      bus_own = 1;
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        bus_drv = 1; bus_ad = W'(a);
        #1 check_drive("R6 bus drive", m, 8'hA5);
        @(negedge clk);
        bus_drv = 0;
        #1 check_drive("R7 bus read", m, 8'hA5);
      end
      bus_own = 0;
    end

    // R8: writes during bus ownership
    wr_mode(0);
    wr_data(8'hFF);
    @(negedge clk);
    bus_own = 1; bus_drv = 1; bus_ad = 8'h5A;
    wr_data(8'h3C);
    wr_mode(1);
    check_drive("R8 held by bus", 1, 8'h3C);
    check("R8 data stored", int'(data_q), 8'h3C);
    @(negedge clk);
    bus_own = 0; bus_drv = 0;
    #1 check_drive("R8 restored", 1, 8'h3C);

    // R9: pin input sweep, two-edge latency
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      pin_in = W'(p);
      @(negedge clk);
      check("R9 one edge", int'(pin_q), (p == 0) ? 0 : p - 1);
      @(negedge clk);
      check("R9 two edges", int'(pin_q), p);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule